// File: doc/BRIEF.md
# Parity-Protected Cache Tag Comparator

This block holds cache tags and reports whether a presented tag matches the one stored at a selected entry. Each entry is nine bits wide: an eight-bit tag and an even-parity bit that the block computes itself. A cache controller drives an entry index and a tag. With the block selected and writes disabled, it reports equality and flags any stored word whose parity is broken. With the block selected and writes enabled, it stores the tag together with its parity bit.

On a write, a dedicated active-low input can corrupt the parity bit deliberately. Diagnostic software uses this to confirm that the error path works. An active-low reset invalidates every entry at once, so afterwards each entry reads as an all-zero word. The interface is synchronous. The match flag and the error flag reflect the inputs sampled at the previous rising clock edge.

Top module: `ptag_compare`

## Requirements
- R1: While `rst_n_i` is low, `match_o` is 1 and `perr_n_o` is 1. This takes effect at once, without waiting for a clock edge.
- R2: After reset, every entry holds tag 0x00 with parity 0. A compare with tag 0x00 gives match 1 and error flag 1. A compare with any other tag gives match 0 and error flag 1.
- R3: A write happens at a rising edge where `sel_n_i`=0 and `wr_n_i`=0. It stores `tag_i` and its even-parity bit (the XOR of the 8 tag bits) at entry `addr_i`. If `perr_force_n_i` was 1 during that write, a later compare of that entry with the same tag gives match 1 and error flag 1.
- R4: A compare happens at a rising edge where `sel_n_i`=0 and `wr_n_i`=1. If the entry holds a valid word and the tag differs, the result is match 0 and error flag 1.
- R5: The result of a compare appears on `match_o` and `perr_n_o` right after the next rising edge. Before that edge, the outputs keep their previous values.
- R6: After a rising edge where `sel_n_i`=1 or `wr_n_i`=0, the outputs are match 1 and error flag 1.
- R7: A write with `perr_force_n_i`=0 stores the inverted parity bit. Every later compare of that entry then gives match 0 and error flag 0, whatever the tag.
- R8: During a compare, `perr_force_n_i` has no effect on either output.
- R9: A write changes only the addressed entry. The other entries keep their contents, including the cleared state left by reset.
- R10: The output pair match 1 with error flag 0 never occurs.
- R11: A reset that arrives after writes returns every entry to the cleared state of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_n_i | input | 1 | Asynchronous active-low clear of all entries and outputs |
| sel_n_i | input | 1 | Active-low block select |
| wr_n_i | input | 1 | Active-low write enable; high means compare |
| addr_i | input | 9 | Entry index |
| tag_i | input | 8 | Tag to store or compare |
| perr_force_n_i | input | 1 | Active-low request to store a corrupted parity bit on a write |
| match_o | output | 1 | High on equality or when not comparing |
| perr_n_o | output | 1 | Low when the compared entry fails its parity check |

## Verification
The bench sweeps all 512 entries in several passes: cleared after reset, written with computed tags, a spread of entries written with corrupted parity, and cleared again by a late reset. Each pass compares with both the stored tag and a neighbouring tag.

Each corner case targets a likely design error:
- A design that leaves parity out of the comparison would show match 1 on corrupted entries.
- A design that lets the force input act during compares would report false errors.
- A design that clears entries with a slow sweep, or not at all, would mismatch right after reset.
- A sample taken just before the edge would catch a design that answers one cycle early.

// File: rtl/ptag_pkg.sv
package ptag_pkg;

   typedef enum logic [1:0] {
      OP_IDLE    = 2'd0,
      OP_WRITE   = 2'd1,
      OP_COMPARE = 2'd2
   } ptag_op_e;

   function automatic ptag_op_e decode_op(input logic sel_n, input logic wr_n);
      if (sel_n)      return OP_IDLE;
      else if (!wr_n) return OP_WRITE;
      else            return OP_COMPARE;
   endfunction

endpackage

// File: rtl/ptag_parity.sv
module ptag_parity #(
   parameter int W = 8
) (
   input  logic [W-1:0] data_i,
   output logic         even_o
);
   localparam int LVL = (W > 1) ? $clog2(W) : 1;
   localparam int PW  = 1 << LVL;

   logic [PW-1:0] padded;
   assign padded = {{(PW-W){1'b0}}, data_i};

   // balanced XOR tree built level by level
   logic [PW-1:0] stage [0:LVL];
   assign stage[0] = padded;

   for (genvar l = 0; l < LVL; l++) begin : g_lvl
      localparam int N = PW >> (l + 1);
      for (genvar k = 0; k < PW; k++) begin : g_node
         if (k < N) begin : g_x
            assign stage[l+1][k] = stage[l][2*k] ^ stage[l][2*k+1];
         end else begin : g_z
            assign stage[l+1][k] = 1'b0;
         end
      end
   end

   assign even_o = stage[LVL][0];

   initial begin
      assert (W >= 1) else $error("ptag_parity: W must be at least 1");
   end
endmodule

// File: rtl/ptag_store.sv
module ptag_store #(
   parameter int ADDR_W = 9,
   parameter int WORD_W = 9
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  blank_q;
   logic [WORD_W-1:0] rd_q;

   // one "blank" flag per entry gives a single-cycle clear of the array
   for (genvar e = 0; e < DEPTH; e++) begin : g_blank
      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i)
            blank_q[e] <= 1'b1;
         else if (we_i && (addr_i == ADDR_W'(e)))
            blank_q[e] <= 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)
         rd_q <= '0;
      else if (re_i)
         rd_q <= blank_q[addr_i] ? '0 : mem[addr_i];
   end

   assign rdata_o = rd_q;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 12) else $error("ptag_store: ADDR_W out of range");
      assert (WORD_W >= 2) else $error("ptag_store: WORD_W too small");
   end

   AST_WRITE_UNBLANKS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      we_i |=> !blank_q[$past(addr_i)]) else $error("AST_WRITE_UNBLANKS"); // R9
endmodule

// File: rtl/ptag_judge.sv
module ptag_judge #(
   parameter int WORD_W = 9
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              cmp_i,
   input  logic [WORD_W-1:0] expect_i,
   input  logic [WORD_W-1:0] stored_i,
   output logic              match_o,
   output logic              perr_n_o
);
   logic              cmp_q;
   logic [WORD_W-1:0] exp_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cmp_q <= 1'b0;
         exp_q <= '0;
      end else begin
         cmp_q <= cmp_i;
         if (cmp_i) exp_q <= expect_i;
      end
   end

   logic equal;
   logic odd_word;
   assign equal    = (stored_i == exp_q);
   assign odd_word = ^stored_i;

   always_comb begin
      match_o  = 1'b1;
      perr_n_o = 1'b1;
      if (cmp_q) begin
         match_o  = equal;
         perr_n_o = !odd_word;
      end
   end

   AST_NO_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(match_o && !perr_n_o)) else $error("AST_NO_UNDEF"); // R10
endmodule

// File: rtl/ptag_compare.sv
module ptag_compare #(
   parameter int ADDR_W = 9,
   parameter int TAG_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              sel_n_i,
   input  logic              wr_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic              perr_force_n_i,
   output logic              match_o,
   output logic              perr_n_o
);
   import ptag_pkg::*;

   localparam int WORD_W = TAG_W + 1;

   ptag_op_e op;
   assign op = decode_op(sel_n_i, wr_n_i);

   logic is_wr, is_cmp, par;
   assign is_wr  = (op == OP_WRITE);
   assign is_cmp = (op == OP_COMPARE);

   ptag_parity #(.W(TAG_W)) i_par (
      .data_i (tag_i),
      .even_o (par)
   );

   logic [WORD_W-1:0] wword, xword, rword;
   assign wword = {par ^ !perr_force_n_i, tag_i};
   assign xword = {par, tag_i};

   ptag_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_store (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .we_i    (is_wr),
      .re_i    (is_cmp),
      .addr_i  (addr_i),
      .wdata_i (wword),
      .rdata_o (rword)
   );

   ptag_judge #(.WORD_W(WORD_W)) i_judge (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .cmp_i    (is_cmp),
      .expect_i (xword),
      .stored_i (rword),
      .match_o  (match_o),
      .perr_n_o (perr_n_o)
   );

   initial begin
      assert (TAG_W >= 1) else $error("ptag_compare: TAG_W must be positive");
   end

   // tracking of the most recent write, used only by the properties below
   logic              lw_v;
   logic              lw_frc_n;
   logic [ADDR_W-1:0] lw_addr;
   logic [TAG_W-1:0]  lw_tag;
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         lw_v     <= 1'b0;
         lw_frc_n <= 1'b1;
         lw_addr  <= '0;
         lw_tag   <= '0;
      end else begin
         lw_v     <= is_wr;
         lw_frc_n <= perr_force_n_i;
         lw_addr  <= addr_i;
         lw_tag   <= tag_i;
      end
   end

   AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (sel_n_i || !wr_n_i) |=> (match_o && perr_n_o)) else $error("AST_IDLE_HIGH"); // R6
   AST_READ_BACK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!sel_n_i && wr_n_i && lw_v && lw_frc_n && addr_i == lw_addr && tag_i == lw_tag)
      |=> (match_o && perr_n_o)) else $error("AST_READ_BACK"); // R3
   AST_FORCED_ERR: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!sel_n_i && wr_n_i && lw_v && !lw_frc_n && addr_i == lw_addr)
      |=> (!match_o && !perr_n_o)) else $error("AST_FORCED_ERR"); // R7
endmodule

// File: tb/test_ptag_compare.sv
`timescale 1ns/1ps
module test_ptag_compare;
   localparam int AW = 9;
   localparam int TW = 8;
   localparam int N  = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, wr_n = 1'b1, frc_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [TW-1:0] tag = '0;
   logic match, perr_n;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   ptag_compare #(.ADDR_W(AW), .TAG_W(TW)) i_ptag_compare (
      .clk_i(clk), .rst_n_i(rst_n), .sel_n_i(sel_n), .wr_n_i(wr_n),
      .addr_i(addr), .tag_i(tag), .perr_force_n_i(frc_n),
      .match_o(match), .perr_n_o(perr_n)
   );

   function automatic logic [TW-1:0] tag_of(int a);
      return TW'((a * 37 + 5) & 8'hFF);
   endfunction
   function automatic logic forced(int a);
      return (a % 7) == 3;
   endfunction

   task automatic check(string req, logic em, logic ep);
      total++;
      if (match !== em || perr_n !== ep) begin
         bad++;
         $display("FAIL %s: addr=%0d tag=%02h got match=%b perr_n=%b exp match=%b perr_n=%b",
                  req, addr, tag, match, perr_n, em, ep);
      end
      // R10: undefined pair never appears
      total++;
      if (match === 1'b1 && perr_n === 1'b0) begin
         bad++;
         $display("FAIL R10: got match=1 perr_n=0 exp not that pair");
      end
   endtask

   task automatic cyc(logic s, logic w, int a, logic [TW-1:0] t, logic f);
      @(negedge clk);
      sel_n = s; wr_n = w; addr = AW'(a); tag = t; frc_n = f;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(8 * 200000);
      bad++; total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2;
      check("R1", 1'b1, 1'b1);
      repeat (3) @(posedge clk);
      #1 check("R1", 1'b1, 1'b1);
      @(negedge clk) rst_n = 1'b1;

      // R2: cleared array, every entry
      for (int a = 0; a < N; a++) begin
         cyc(0, 1, a, 8'h00, 1); check("R2", 1'b1, 1'b1);
         cyc(0, 1, a, tag_of(a) | 8'h01, 1); check("R2", 1'b0, 1'b1);
      end

      // R9: single write leaves neighbours cleared
      cyc(0, 0, 100, 8'hA5, 1); check("R6", 1'b1, 1'b1);
      cyc(0, 1, 99, 8'h00, 1);  check("R9", 1'b1, 1'b1);
      cyc(0, 1, 101, 8'h00, 1); check("R9", 1'b1, 1'b1);
      cyc(0, 1, 100, 8'hA5, 1); check("R3", 1'b1, 1'b1);

      // fill every entry, some with corrupted parity
      for (int a = 0; a < N; a++) begin
         cyc(0, 0, a, tag_of(a), forced(a) ? 1'b0 : 1'b1);
         check("R6", 1'b1, 1'b1);
      end

      for (int a = 0; a < N; a++) begin
         logic f;
         f = (a % 2) == 0;          // R8: force pin toggled during compares
         cyc(0, 1, a, tag_of(a), f);
         if (forced(a)) check("R7", 1'b0, 1'b0);
         else           check("R3", 1'b1, 1'b1);
         cyc(0, 1, a, tag_of(a) ^ 8'h01, !f);
         if (forced(a)) check("R7", 1'b0, 1'b0);
         else           check("R4", 1'b0, 1'b1);
      end

      // R8: force input low on a compare of a clean entry
      cyc(0, 1, 1, tag_of(1), 0); check("R8", 1'b1, 1'b1);
      cyc(0, 1, 1, tag_of(1) ^ 8'h80, 0); check("R8", 1'b0, 1'b1);

      // R6: deselect after a mismatch, and write-low while deselected
      cyc(0, 1, 2, tag_of(2) ^ 8'h10, 1); check("R4", 1'b0, 1'b1);
      cyc(1, 1, 2, tag_of(2) ^ 8'h10, 1); check("R6", 1'b1, 1'b1);
      cyc(1, 0, 2, 8'h00, 1); check("R6", 1'b1, 1'b1);
      cyc(0, 1, 2, tag_of(2), 1); check("R9", 1'b1, 1'b1);

      // R5: outputs change only at the edge after the compare
      cyc(1, 1, 0, 8'h00, 1); check("R6", 1'b1, 1'b1);
      @(negedge clk);
      sel_n = 0; wr_n = 1; addr = AW'(5); tag = tag_of(5) ^ 8'h04; frc_n = 1;
      #3 check("R5", 1'b1, 1'b1);
      @(posedge clk); #1 check("R5", 1'b0, 1'b1);

      // R1: asynchronous reset between edges
      #1 rst_n = 1'b0;
      #1 check("R1", 1'b1, 1'b1);
      @(negedge clk) rst_n = 1'b1;

      // R11: all entries cleared again
      for (int a = 0; a < N; a++) begin
         cyc(0, 1, a, 8'h00, 1);
         if (a < 8 || forced(a)) check("R11", 1'b1, 1'b1);
         else                    check("R11", 1'b1, 1'b1);
      end
      cyc(0, 1, 3, tag_of(3), 1); check("R11", tag_of(3) == 8'h00, 1'b1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule